// File: doc/BRIEF.md
# Dual-Compare Interval Timer with Guarded Run Control

This block is a 16-bit interval timer for a peripheral bus. It counts one step on each cycle in which the tick-enable input is high and the timer is running. When the count reaches the last value of the active interval, it wraps to zero, sets a sticky maxcount flag and, if interrupts are allowed, raises an interrupt request. The request stays asserted until an acknowledge pulse arrives.

Software reaches four word registers through a single-cycle write port. Reads are combinational: `bus_rdata_o` always shows the register that `bus_addr_i` selects. The limit registers are called A and B.

In single mode each interval uses limit A. In dual mode the intervals alternate between A and B, and a status bit shows which limit is active. The run bit in the control word changes only when a guard bit is written as 1 in the same write. This prevents a write meant for the other fields from stopping or starting the timer by accident.

Top module: `timer_dual_cmp`

## Requirements
- R1: After reset, all four registers read 0000h and `irq_o` is 0.
- R2: In a write to the control word (address 0), bit 15 (RUN) takes the written value only when bit 14 (GUARD) is 1 in that same write. When GUARD is 0, RUN keeps its old value. IEN (bit 13), DUAL (bit 1) and REPEAT (bit 0) update on every control write, whatever the value of GUARD.
- R3: The control word reads GUARD (bit 14) as 0, and bits 11:6 and 4:2 as 0.
- R4: While RUN is 1 and `tick_i` is 1 on an edge, the count (address 1) goes up by one. While RUN is 0, or `tick_i` is 0, the count holds.
- R5: With limit L, a tick at count L-1 returns the count to 0 and sets the maxcount flag MAXF (bit 5). The interval is therefore L ticks long. A limit of 0 gives 65536 ticks, so the wrap happens from FFFFh.
- R6: With DUAL set, every wrap swaps the active limit between A (address 2) and B (address 3). Control bit 12 (BSEL) reads 1 while B is active. A control write with DUAL=0 returns the timer to A.
- R7: A wrap that happens while IEN is 1 asserts `irq_o` on the next cycle. While IEN is 0, a wrap never raises the request.
- R8: Once raised, `irq_o` stays asserted until a cycle with `irq_ack_i` high, even if RUN is cleared. A wrap that coincides with the acknowledge keeps the request asserted.
- R9: MAXF stays set until a control write with bit 5 equal to 0. Writing 1 to bit 5 never sets it. A wrap in the same cycle as such a write leaves MAXF set.
- R10: With REPEAT=0, the hardware clears RUN when a cycle ends. In single mode this happens at every wrap. In dual mode it happens at the wrap that ends the B interval.
- R11: Writes to the count register and to the A and B registers take effect on the next edge. A count write overrides the tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 count, 2 limit A, 3 limit B |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the selected register |
| irq_ack_i | input | 1 | Clears the pending request |
| irq_o | output | 1 | Pending interrupt request |

## Verification
The bench first writes the control word with GUARD low and then reads it back. A design that lets RUN through on that write would start counting. The bench also checks that GUARD always reads as zero.

In dual mode the bench walks through an A interval and then a B interval, confirming BSEL at each wrap. A design that never swaps limits, or that reports the swap one interval late, would show the wrong BSEL value and the wrong period.

Other directed cases cover:
- clearing RUN while a request is pending, where a faulty design would drop `irq_o`;
- a limit of zero, where an off-by-one design would wrap at 0 or never wrap at all;
- one-shot stopping in both modes;
- MAXF ignoring a written 1.

Several thousand random cycles then compare every readback against a bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;

    localparam int B_RUN   = 15;
    localparam int B_GUARD = 14;
    localparam int B_IEN   = 13;
    localparam int B_BSEL  = 12;
    localparam int B_MAXF  = 5;
    localparam int B_DUAL  = 1;
    localparam int B_REP   = 0;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_LIMA = 2'd2;
    localparam logic [ADDR_W-1:0] A_LIMB = 2'd3;

    typedef struct packed {
        logic             run;
        logic             ien;
        logic             bsel;
        logic             maxf;
        logic             dual;
        logic             rep;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim_a;
        logic [CNT_W-1:0] lim_b;
    } tmr_state_t;
endpackage

// File: rtl/tmr_match.sv
module tmr_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] lim_a_i,
    input  logic [W-1:0] lim_b_i,
    input  logic         dual_i,
    input  logic         bsel_i,
    input  logic         run_i,
    input  logic         tick_i,
    output logic         step_o,
    output logic         wrap_o,
    output logic         end_cycle_o
);
    logic [W-1:0] limit;
    logic [W-1:0] last;

    always_comb begin
        limit       = (dual_i && bsel_i) ? lim_b_i : lim_a_i;
        // limit 0 wraps to all ones: a full 2^W period
        last        = limit - W'(1);
        step_o      = run_i && tick_i;
        wrap_o      = step_o && (cnt_i == last);
        end_cycle_o = wrap_o && (!dual_i || bsel_i);
    end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic ack_i,
    output logic irq_o
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (ack_i) irq_d = 1'b0;
        if (set_i) irq_d = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) irq_q <= 1'b0;
        else         irq_q <= irq_d;
    end

    assign irq_o = irq_q;

    AST_IRQ_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_q && !ack_i) |=> irq_q);                              // R8
    AST_IRQ_NEEDS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_q && !set_i) |=> !irq_q);                            // R7
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  tmr_state_t        st_i,
    output logic [CNT_W-1:0]  rdata_o
);
    logic [CNT_W-1:0] ctrl_word;

    always_comb begin
        ctrl_word         = '0;
        ctrl_word[B_RUN]  = st_i.run;
        ctrl_word[B_IEN]  = st_i.ien;
        ctrl_word[B_BSEL] = st_i.bsel;
        ctrl_word[B_MAXF] = st_i.maxf;
        ctrl_word[B_DUAL] = st_i.dual;
        ctrl_word[B_REP]  = st_i.rep;
        unique case (addr_i)
            A_CTRL:  rdata_o = ctrl_word;
            A_CNT:   rdata_o = st_i.cnt;
            A_LIMA:  rdata_o = st_i.lim_a;
            default: rdata_o = st_i.lim_b;
        endcase
    end
endmodule

// File: rtl/timer_dual_cmp.sv
module timer_dual_cmp
    import tmr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [CNT_W-1:0]  bus_wdata_i,
    output logic [CNT_W-1:0]  bus_rdata_o,
    input  logic              irq_ack_i,
    output logic              irq_o
);
    tmr_state_t s_d, s_q;
    logic ctrl_wr, cnt_wr, lima_wr, limb_wr;
    logic step, wrap, end_cycle;
    logic unused_wbits;

    assign ctrl_wr = bus_wr_i && (bus_addr_i == A_CTRL);
    assign cnt_wr  = bus_wr_i && (bus_addr_i == A_CNT);
    assign lima_wr = bus_wr_i && (bus_addr_i == A_LIMA);
    assign limb_wr = bus_wr_i && (bus_addr_i == A_LIMB);
    assign unused_wbits = ^{bus_wdata_i[B_BSEL], bus_wdata_i[11:6], bus_wdata_i[4:2]};

    tmr_match #(.W(CNT_W)) u_match (
        .cnt_i       (s_q.cnt),
        .lim_a_i     (s_q.lim_a),
        .lim_b_i     (s_q.lim_b),
        .dual_i      (s_q.dual),
        .bsel_i      (s_q.bsel),
        .run_i       (s_q.run),
        .tick_i      (tick_i),
        .step_o      (step),
        .wrap_o      (wrap),
        .end_cycle_o (end_cycle)
    );

    always_comb begin
        s_d = s_q;
        if (step) s_d.cnt = wrap ? '0 : s_q.cnt + CNT_W'(1);
        if (wrap && s_q.dual) s_d.bsel = !s_q.bsel;
        if (end_cycle && !s_q.rep) s_d.run = 1'b0;
        if (ctrl_wr) begin
            if (bus_wdata_i[B_GUARD]) s_d.run = bus_wdata_i[B_RUN];
            s_d.ien  = bus_wdata_i[B_IEN];
            s_d.dual = bus_wdata_i[B_DUAL];
            s_d.rep  = bus_wdata_i[B_REP];
            if (!bus_wdata_i[B_DUAL]) s_d.bsel = 1'b0;
            if (!bus_wdata_i[B_MAXF]) s_d.maxf = 1'b0;
        end
        if (wrap)    s_d.maxf  = 1'b1;
        if (cnt_wr)  s_d.cnt   = bus_wdata_i;
        if (lima_wr) s_d.lim_a = bus_wdata_i;
        if (limb_wr) s_d.lim_b = bus_wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    tmr_irq u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (wrap && s_q.ien),
        .ack_i  (irq_ack_i),
        .irq_o  (irq_o)
    );

    tmr_rdmux u_rd (
        .addr_i  (bus_addr_i),
        .st_i    (s_q),
        .rdata_o (bus_rdata_o)
    );

    AST_RUN_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && !bus_wdata_i[B_GUARD] && !end_cycle) |=> (s_q.run == $past(s_q.run))); // R2
    AST_CTRL_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_CTRL) |-> (!bus_rdata_o[B_GUARD] && bus_rdata_o[11:6] == '0)); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.run && !cnt_wr) |=> $stable(s_q.cnt));               // R4
    AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && !wrap && !cnt_wr) |=> (s_q.cnt == $past(s_q.cnt) + CNT_W'(1))); // R4
    AST_MAXF_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap |=> s_q.maxf);                                        // R5
    AST_BSEL_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap && s_q.dual && !ctrl_wr) |=> (s_q.bsel != $past(s_q.bsel))); // R6
    AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (end_cycle && !s_q.rep && !ctrl_wr) |=> !s_q.run);         // R10
endmodule

// File: tb/test_timer_dual_cmp.sv
module test_timer_dual_cmp;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        ack = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        m_run, m_ien, m_bsel, m_maxf, m_dual, m_rep, m_irq;
    logic [15:0] m_cnt, m_a, m_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    timer_dual_cmp i_timer_dual_cmp (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_wr_i(bus_wr),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_ack_i(ack), .irq_o(irq)
    );

    task automatic model_reset();
        {m_run, m_ien, m_bsel, m_maxf, m_dual, m_rep, m_irq} = '0;
        m_cnt = 0; m_a = 0; m_b = 0;
    endtask

    function automatic logic [15:0] exp_read(input logic [1:0] ad);
        case (ad)
            2'd0: exp_read = {m_run, 1'b0, m_ien, m_bsel, 6'b0, m_maxf, 3'b0, m_dual, m_rep};
            2'd1: exp_read = m_cnt;
            2'd2: exp_read = m_a;
            default: exp_read = m_b;
        endcase
    endfunction

    task automatic model_step(input logic wr, input logic [1:0] ad,
                              input logic [15:0] wd, input logic tk, input logic ak);
        logic [15:0] last;
        logic stp, wrp, endc;
        logic n_run, n_bsel, n_maxf, n_irq, n_ien, n_dual, n_rep;
        logic [15:0] n_cnt;
        last = ((m_dual && m_bsel) ? m_b : m_a) - 16'd1;
        stp  = m_run && tk;
        wrp  = stp && (m_cnt == last);
        endc = wrp && (!m_dual || m_bsel);
        n_cnt = m_cnt; n_run = m_run; n_bsel = m_bsel; n_maxf = m_maxf;
        n_ien = m_ien; n_dual = m_dual; n_rep = m_rep; n_irq = m_irq;
        if (stp) n_cnt = wrp ? 16'd0 : m_cnt + 16'd1;
        if (wrp && m_dual) n_bsel = !m_bsel;
        if (endc && !m_rep) n_run = 1'b0;
        if (wr && ad == 2'd0) begin
            if (wd[14]) n_run = wd[15];
            n_ien = wd[13]; n_dual = wd[1]; n_rep = wd[0];
            if (!wd[1]) n_bsel = 1'b0;
            if (!wd[5]) n_maxf = 1'b0;
        end
        if (wrp) n_maxf = 1'b1;
        if (ak) n_irq = 1'b0;
        if (wrp && m_ien) n_irq = 1'b1;
        if (wr && ad == 2'd1) n_cnt = wd;
        if (wr && ad == 2'd2) m_a = wd;
        if (wr && ad == 2'd3) m_b = wd;
        m_cnt = n_cnt; m_run = n_run; m_bsel = n_bsel; m_maxf = n_maxf;
        m_ien = n_ien; m_dual = n_dual; m_rep = n_rep; m_irq = n_irq;
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] ad, input logic [15:0] exp);
        bus_addr = ad;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic cyc(input logic wr, input logic [1:0] ad, input logic [15:0] wd,
                       input logic tk, input logic ak);
        bus_wr = wr; bus_addr = ad; bus_wdata = wd; tick = tk; ack = ak;
        @(posedge clk);
        model_step(wr, ad, wd, tk, ak);
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0; ack = 1'b0;
        #1;
        chk("R8 irq versus model", {15'b0, irq}, {15'b0, m_irq});
    endtask

    task automatic wr(input logic [1:0] ad, input logic [15:0] wd);
        cyc(1'b1, ad, wd, 1'b0, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0]  ad;
        logic [15:0] wd;
        void'($urandom(32'd4242));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int a = 0; a < 4; a++) rd_chk("R1 reset value", 2'(a), 16'h0000);
        chk("R1 reset irq", {15'b0, irq}, 16'h0);

        // R2: RUN set without guard is ignored, other fields update
        wr(2'd2, 16'd3);
        wr(2'd0, 16'hA003);
        rd_chk("R2 run ignored without guard", 2'd0, 16'h2003);
        ticks(2);
        rd_chk("R2 count idle while not running", 2'd1, 16'h0000);
        wr(2'd0, 16'hE001);
        rd_chk("R3 guard reads zero", 2'd0, 16'hA001);

        // R5/R7 single mode, limit 3
        ticks(2);
        rd_chk("R4 count advanced", 2'd1, 16'd2);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
        rd_chk("R4 hold without tick", 2'd1, 16'd2);
        ticks(1);
        rd_chk("R5 wrap to zero", 2'd1, 16'd0);
        rd_chk("R5 maxf set", 2'd0, 16'hA021);
        chk("R7 irq after wrap", {15'b0, irq}, 16'd1);

        // R8 request survives stopping
        wr(2'd0, 16'h6021);
        ticks(3);
        chk("R8 irq held after stop", {15'b0, irq}, 16'd1);
        rd_chk("R4 count held while stopped", 2'd1, 16'd0);
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
        chk("R8 irq cleared by ack", {15'b0, irq}, 16'd0);

        // R9 MAXF write 1 keeps, write 0 clears, write 1 never sets
        rd_chk("R9 maxf still set", 2'd0, 16'h2021);
        wr(2'd0, 16'h2001);
        rd_chk("R9 maxf cleared", 2'd0, 16'h2000 | 16'h0001);
        wr(2'd0, 16'h2021);
        rd_chk("R9 maxf not set by write", 2'd0, 16'h2001);

        // R6 dual mode A=2 B=3
        wr(2'd2, 16'd2);
        wr(2'd3, 16'd3);
        wr(2'd0, 16'hE003);
        ticks(2);
        rd_chk("R6 bsel after A interval", 2'd0, 16'hB023);
        cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b1);
        chk("R7 ack clears irq", {15'b0, irq}, 16'd0);
        ticks(2);
        rd_chk("R6 back to A after B interval", 2'd0, 16'hA023);
        chk("R7 irq on B wrap", {15'b0, irq}, 16'd1);

        // R10 one-shot dual: stops at end of B
        wr(2'd0, 16'hC002);
        ticks(2);
        rd_chk("R10 still running after A", 2'd0, 16'h9022);
        ticks(3);
        rd_chk("R10 stopped after B", 2'd0, 16'h0022);
        ticks(2);
        rd_chk("R10 count frozen", 2'd1, 16'd0);

        // R10 one-shot single + R7 no irq with IEN=0
        cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
        wr(2'd0, 16'hC000);
        ticks(2);
        rd_chk("R10 single stops", 2'd0, 16'h0020);
        chk("R7 no irq when disabled", {15'b0, irq}, 16'd0);

        // R5 limit 0 full period, R11 count write wins over tick
        wr(2'd2, 16'd0);
        wr(2'd0, 16'hC001);
        cyc(1'b1, 2'd1, 16'hFFFE, 1'b1, 1'b0);
        rd_chk("R11 count write overrides tick", 2'd1, 16'hFFFE);
        ticks(1);
        rd_chk("R5 no wrap at FFFF", 2'd1, 16'hFFFF);
        wr(2'd0, 16'h0001);
        ticks(1);
        rd_chk("R5 full period wrap", 2'd1, 16'h0000);
        rd_chk("R5 maxf on full wrap", 2'd0, 16'h8021);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic w;
            w  = ($urandom_range(0, 9) < 2);
            ad = 2'($urandom_range(0, 3));
            case (ad)
                2'd0: wd = 16'($urandom);
                2'd1: wd = $urandom_range(0, 1) ? (16'hFFF0 | 16'($urandom_range(0, 15)))
                                                : 16'($urandom_range(0, 5));
                default: wd = 16'($urandom_range(0, 6));
            endcase
            cyc(w, ad, wd, ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) == 0));
            ad = 2'($urandom_range(0, 3));
            rd_chk("R11 random readback", ad, exp_read(ad));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule